// File: doc/BRIEF.md
# Block-Granular SRAM Security Gate

This block decides, for every access to two on-chip SRAM banks, whether the requester may touch the addressed memory. Each 256-byte block of either bank has one security bit. A set bit means the block is reserved for the secure world. A clear bit opens it to non-secure requesters. Thirty-two bits are packed into one 32-bit vector register, and each register covers an 8 KB superblock. The larger bank is 192 KB and has 24 such registers. The smaller bank is 64 KB and has 8.

Secure firmware fills the vectors through a small register port. The port accepts writes only from a secure requester. Non-secure requesters can neither change the vectors nor read them back. The bus fabric presents each SRAM access on the check port as a bank, a byte offset within the bank and the requester's security state. One cycle later the block answers with a permit, or with a one-cycle illegal-access pulse.

Top module: `sram_blk_gate`

## Requirements
- R1: After reset every block of both banks is secure: a secure read of any implemented register returns 0xFFFFFFFF, and a non-secure check of any offset is denied.
- R2: For a check, the vector register index is chk_offset[17:13] and the bit within it is chk_offset[12:8]. A bit value of 1 marks that block secure and 0 marks it non-secure.
- R3: A check from a secure requester (chk_secure=1) is always permitted, whatever the block's bit.
- R4: The response appears in the cycle after chk_valid. A non-secure check of a secure block gives chk_permit=0 and chk_illegal=1 for exactly that one cycle. With no request, both outputs are 0.
- R5: Register address decode: cfg_addr[7] selects the bank (0 = 192 KB bank, 1 = 64 KB bank), and cfg_addr[6:2] is the register index, so register n of a bank sits at its base plus 4·n. Bank 0 has 24 registers and bank 1 has 8.
- R6: Writes to an index at or beyond the bank's register count are ignored, and reads there return zero.
- R7: A write with cfg_secure=0 is dropped and leaves the vectors unchanged.
- R8: A read with cfg_secure=0 returns zero.
- R9: Read data appears on cfg_rdata in the cycle after the read request and holds until the next read.
- R10: A check whose register index is at or beyond the bank's register count is treated as hitting a secure block.
- R11: A vector write affects checks that are issued from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Register port request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_secure | input | 1 | Security state of the register requester |
| cfg_addr | input | 8 | Byte address of the vector register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| chk_valid | input | 1 | Access check request |
| chk_bank | input | 1 | SRAM bank of the access |
| chk_offset | input | 18 | Byte offset within the bank |
| chk_secure | input | 1 | Security state of the accessing master |
| chk_permit | output | 1 | Access allowed (one cycle after request) |
| chk_illegal | output | 1 | Illegal access pulse (one cycle after request) |

## Verification
Checks are aimed at blocks whose vector bits were written as mixed patterns such as 0xFFFF00FF. An offset inside the cleared byte and one just outside it separate a correct register and bit split from a shifted one. The same offsets are then presented by secure and non-secure requesters, which shows whether the requester state or the block bit decides the outcome. Indexes past each bank's register count are written, read and checked to show that the two banks have different limits. Register accesses from a non-secure requester are followed by secure read-back and checks, so a write that is dropped can be told apart from one that lands.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
    localparam int VEC_W = 32;
    localparam int BIT_W = $clog2(VEC_W);

    typedef struct packed {
        logic [VEC_W-1:0] rdata;
        logic             permit;
        logic             illegal;
    } gate_st_t;
endpackage

// File: rtl/sbg_addr_split.sv
module sbg_addr_split #(
    parameter int OFS_W     = 18,
    parameter int BLK_SHIFT = 8,
    parameter int BIT_W     = 5,
    parameter int IDX_W     = 5
) (
    input  logic [OFS_W-BLK_SHIFT-1:0] ofs_hi,
    output logic [IDX_W-1:0]           reg_idx,
    output logic [BIT_W-1:0]           bit_idx
);
    always_comb begin
        bit_idx = ofs_hi[BIT_W-1:0];
        reg_idx = ofs_hi[BIT_W +: IDX_W];
    end
endmodule

// File: rtl/sbg_vec_bank.sv
module sbg_vec_bank #(
    parameter int N_REGS = 24,
    parameter int VEC_W  = 32,
    parameter int BIT_W  = 5,
    parameter int IDX_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [BIT_W-1:0] lk_bit,
    output logic             lk_secure
);
    localparam int SEL_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;
    localparam logic [IDX_W:0] LIM = N_REGS[IDX_W:0];

    typedef struct packed {
        logic [N_REGS-1:0][VEC_W-1:0] vec;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && ({1'b0, wr_idx} < LIM)) begin
            st_d.vec[wr_idx[SEL_W-1:0]] = wr_data;
        end
        rd_data = ({1'b0, rd_idx} < LIM) ? st_q.vec[rd_idx[SEL_W-1:0]] : '0;
        if ({1'b0, lk_idx} < LIM) begin
            lk_secure = st_q.vec[lk_idx[SEL_W-1:0]][lk_bit];
        end else begin
            lk_secure = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sram_blk_gate.sv
module sram_blk_gate
    import sbg_pkg::*;
#(
    parameter int BANK0_REGS = 24,
    parameter int BANK1_REGS = 8,
    parameter int OFS_W      = 18,
    parameter int BLK_SHIFT  = 8,
    parameter int CFG_AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_wr,
    input  logic              cfg_secure,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [VEC_W-1:0]  cfg_wdata,
    output logic [VEC_W-1:0]  cfg_rdata,
    input  logic              chk_valid,
    input  logic              chk_bank,
    input  logic [OFS_W-1:0]  chk_offset,
    input  logic              chk_secure,
    output logic              chk_permit,
    output logic              chk_illegal
);
    localparam int IDX_W = OFS_W - BLK_SHIFT - BIT_W;
    localparam int N_BANKS = 2;

    gate_st_t st_d, st_q;

    logic                               cfg_bank;
    logic [IDX_W-1:0]                   cfg_idx;
    logic                               wr_ok;
    logic [IDX_W-1:0]                   lk_idx;
    logic [BIT_W-1:0]                   lk_bit;
    logic [N_BANKS-1:0][VEC_W-1:0]      bank_rd;
    logic [N_BANKS-1:0]                 bank_sec;
    logic                               unused_low_bits;

    assign cfg_bank        = cfg_addr[CFG_AW-1];
    assign cfg_idx         = cfg_addr[2 +: IDX_W];
    assign wr_ok           = cfg_en && cfg_wr && cfg_secure;
    assign unused_low_bits = ^{cfg_addr[1:0], chk_offset[BLK_SHIFT-1:0]};

    sbg_addr_split #(
        .OFS_W(OFS_W), .BLK_SHIFT(BLK_SHIFT), .BIT_W(BIT_W), .IDX_W(IDX_W)
    ) u_split (
        .ofs_hi (chk_offset[OFS_W-1:BLK_SHIFT]),
        .reg_idx(lk_idx),
        .bit_idx(lk_bit)
    );

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        localparam int CNT = (g == 0) ? BANK0_REGS : BANK1_REGS;
        sbg_vec_bank #(
            .N_REGS(CNT), .VEC_W(VEC_W), .BIT_W(BIT_W), .IDX_W(IDX_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_ok && (cfg_bank == 1'(g))),
            .wr_idx   (cfg_idx),
            .wr_data  (cfg_wdata),
            .rd_idx   (cfg_idx),
            .rd_data  (bank_rd[g]),
            .lk_idx   (lk_idx),
            .lk_bit   (lk_bit),
            .lk_secure(bank_sec[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (cfg_en && !cfg_wr) begin
            st_d.rdata = cfg_secure ? bank_rd[cfg_bank] : '0;
        end
        st_d.permit  = chk_valid && (chk_secure || !bank_sec[chk_bank]);
        st_d.illegal = chk_valid && !chk_secure && bank_sec[chk_bank];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata   = st_q.rdata;
    assign chk_permit  = st_q.permit;
    assign chk_illegal = st_q.illegal;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        cfg_wr,
    input logic        cfg_secure,
    input logic [31:0] cfg_rdata,
    input logic        chk_valid,
    input logic        chk_secure,
    input logic        chk_permit,
    input logic        chk_illegal
);
    AST_SECURE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && chk_secure |=> chk_permit && !chk_illegal); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_permit && !chk_illegal); // R4

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> (chk_permit != chk_illegal)); // R4

    AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_illegal) |-> $past(chk_valid && !chk_secure)); // R4

    AST_NS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en && !cfg_wr && !cfg_secure |=> cfg_rdata == 32'h0); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && !cfg_wr) |=> $stable(cfg_rdata)); // R9
endmodule

bind sram_blk_gate sbg_checker u_sbg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_wr     (cfg_wr),
    .cfg_secure (cfg_secure),
    .cfg_rdata  (cfg_rdata),
    .chk_valid  (chk_valid),
    .chk_secure (chk_secure),
    .chk_permit (chk_permit),
    .chk_illegal(chk_illegal)
);

// File: tb/sram_blk_gate_bench.sv
module sram_blk_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0, cfg_secure = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        chk_valid = 1'b0, chk_bank = 1'b0, chk_secure = 1'b0;
    logic [17:0] chk_offset = '0;
    logic        chk_permit, chk_illegal;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        int          due;
        int          kind;      // 0 check response, 1 read data, 2 idle
        logic        permit;
        logic        illegal;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [31:0] mdl [2][32];
    logic [31:0] last_rd = '0;

    always #2.5 clk = ~clk;

    sram_blk_gate u_sram_blk_gate (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_secure(cfg_secure),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .chk_valid(chk_valid), .chk_bank(chk_bank), .chk_offset(chk_offset),
        .chk_secure(chk_secure), .chk_permit(chk_permit), .chk_illegal(chk_illegal)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int bank_cnt(input int b);
        return (b == 0) ? 24 : 8;
    endfunction

    task automatic clear_in();
        cfg_en = 0; cfg_wr = 0; cfg_secure = 0; chk_valid = 0; chk_secure = 0;
    endtask

    task automatic do_write(input int b, input int idx, input logic [31:0] d, input logic sec);
        @(negedge clk);
        clear_in();
        cfg_en = 1; cfg_wr = 1; cfg_secure = sec;
        cfg_addr = {b[0], idx[4:0], 2'b00}; cfg_wdata = d;
        if (sec && idx < bank_cnt(b)) mdl[b][idx] = d;
    endtask

    task automatic do_read(input int b, input int idx, input logic sec, input string tag);
        exp_t e;
        @(negedge clk);
        clear_in();
        cfg_en = 1; cfg_wr = 0; cfg_secure = sec;
        cfg_addr = {b[0], idx[4:0], 2'b00};
        e.due = cyc + 1; e.kind = 1; e.permit = 0; e.illegal = 0; e.tag = tag;
        e.rdata = (!sec || idx >= bank_cnt(b)) ? 32'h0 : mdl[b][idx];
        last_rd = e.rdata;
        sb.push_back(e);
    endtask

    task automatic do_chk(input int b, input int idx, input int bitn, input logic sec, input string tag);
        exp_t e;
        logic blk_sec;
        @(negedge clk);
        clear_in();
        chk_valid = 1; chk_bank = b[0]; chk_secure = sec;
        chk_offset = {idx[4:0], bitn[4:0], 8'h5A};
        blk_sec = (idx >= bank_cnt(b)) ? 1'b1 : mdl[b][idx][bitn];
        e.due = cyc + 1; e.kind = 0; e.tag = tag; e.rdata = '0;
        e.permit = sec || !blk_sec;
        e.illegal = !sec && blk_sec;
        sb.push_back(e);
    endtask

    task automatic do_idle(input string tag);
        exp_t e;
        @(negedge clk);
        clear_in();
        e.due = cyc + 1; e.kind = 2; e.permit = 0; e.illegal = 0;
        e.rdata = last_rd; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (e.kind == 1 || e.kind == 2) begin
                if (cfg_rdata !== e.rdata) begin
                    bad++;
                    $display("FAIL %s: rdata actual=%h expected=%h", e.tag, cfg_rdata, e.rdata);
                end
            end
            if (e.kind == 0 || e.kind == 2) begin
                if (chk_permit !== e.permit || chk_illegal !== e.illegal) begin
                    bad++;
                    $display("FAIL %s: permit/illegal actual=%b%b expected=%b%b",
                             e.tag, chk_permit, chk_illegal, e.permit, e.illegal);
                end
            end
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 32; i++) mdl[b][i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        total++;
        if (chk_permit !== 1'b0 || chk_illegal !== 1'b0 || cfg_rdata !== 32'h0) begin
            bad++;
            $display("FAIL R1: reset outputs actual=%b%b %h expected=00 0", chk_permit, chk_illegal, cfg_rdata);
        end
        rst_n = 1'b1;

        do_read(0, 0, 1, "R1 bank0 reg0 reset");
        do_read(1, 7, 1, "R1 bank1 reg7 reset");
        do_chk(0, 23, 31, 0, "R1 ns check after reset");
        do_chk(1, 3, 0, 0, "R1 ns check bank1 after reset");

        do_write(0, 3, 32'hFFFF_00FF, 1);
        do_chk(0, 3, 9, 0, "R11 R2 cleared block right after write");
        do_chk(0, 3, 16, 0, "R2 set block just above cleared byte");
        do_chk(0, 3, 7, 0, "R2 set block just below cleared byte");
        do_chk(0, 3, 16, 1, "R3 secure access to secure block");
        do_idle("R4 illegal lasts one cycle");
        do_write(0, 12, 32'h0, 1);
        do_chk(0, 12, 31, 0, "R2 whole superblock open");
        do_chk(0, 13, 0, 0, "R2 neighbour superblock still secure");

        do_write(1, 7, 32'hA5A5_0F0F, 1);
        do_read(1, 7, 1, "R5 bank1 last register");
        do_idle("R9 read data holds");
        do_idle("R9 read data still holds");
        do_chk(1, 7, 4, 0, "R5 bank1 bit4 clear");
        do_chk(1, 7, 0, 0, "R5 bank1 bit0 set");
        do_write(0, 23, 32'h1234_5678, 1);
        do_read(0, 23, 1, "R5 bank0 last register");

        do_write(1, 10, 32'h0, 1);
        do_read(1, 10, 1, "R6 bank1 index past count");
        do_read(0, 30, 1, "R6 bank0 index past count");
        do_chk(1, 10, 3, 0, "R10 bank1 index past count is secure");
        do_chk(0, 24, 0, 0, "R10 bank0 index past count is secure");

        do_write(1, 0, 32'h0, 0);
        do_read(1, 0, 1, "R7 ns write dropped readback");
        do_chk(1, 0, 5, 0, "R7 ns write dropped check");
        do_read(0, 3, 0, "R8 ns read returns zero");
        do_idle("R9 zero held after ns read");
        do_chk(0, 3, 9, 1, "R3 secure access to open block");
        do_idle("R4 quiet with no request");
        do_idle("final drain");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule